// File: doc/BRIEF.md
# Doorbell-driven transfer ring tracker

This block is the device-side bookkeeping for a set of transfer rings that live in host memory, one ring per logical, one-way channel. For each channel the host loads a ring base address, a ring length, a starting read index and a write index through a simple register-write port. The host publishes new work by moving the write index forward and then striking that channel's doorbell. The doorbell is the only event that makes a channel eligible for service. A write-index update on its own does nothing.

Channels that hold a doorbell and unserviced elements compete in round-robin order. The block issues one element-fetch request at a time on a valid/ready stream, carrying the channel number and the byte address of the element at the read index. A stalled consumer holds `fetch_ready` low, and the request stays unchanged until it is taken. After the hand-off, the memory side returns one acknowledge pulse with the fetched element's chain bit. The read index then advances and wraps at the ring length. A set chain bit keeps the grant on the same channel, so every element of a multi-element descriptor is fetched back to back. Descriptor completion is signalled only for the element that ends the chain.

Doorbells that hit an empty ring are dropped and counted. A per-channel reset reloads the read index from the programmed start value and drops the channel's pending doorbell.

Top module: `tr_ring_tracker`

## Requirements
- R1: After reset, `pend_mask` is all zero, `fetch_valid` and `done_valid` are low, and `db_ign_cnt` is zero.
- R2: A doorbell on a channel whose read index differs from its write index sets that channel's bit in `pend_mask` on the next cycle. A write-index update without a doorbell leaves `pend_mask` unchanged. A pending bit is never set while the ring is empty.
- R3: A doorbell on a channel whose read index equals its write index is ignored: `pend_mask` stays clear and `db_ign_cnt` rises by exactly one.
- R4: A fetch request carries `fetch_ch` = the served channel and `fetch_addr` = base + read index × ELEM_BYTES. While `fetch_ready` is low, `fetch_valid` stays high and both fields stay stable.
- R5: Each `elem_ack` advances the served channel's read index by one, returning to 0 after index length−1. When the read index reaches the write index, the channel's pending bit clears on the same edge.
- R6: Without a chain lock, the next channel granted is the first pending channel after the last one granted, searching upward in index order and wrapping. The first search after reset starts at channel 0.
- R7: An acknowledge with `elem_chain`=1 keeps the grant on the same channel for its next element, and `done_valid` stays low. An acknowledge with `elem_chain`=0 pulses `done_valid` for one cycle on the following cycle, with `done_ch` naming the channel.
- R8: A channel reset (`crst_valid` with `crst_ch`) sets that channel's read index to its programmed start value and clears its pending bit.
- R9: At most one fetch is outstanding. After a request is taken, `fetch_valid` stays low until the acknowledge has been received.
- R10: Configuration writes take effect on the next edge. `cfg_sel` codes: 0 = ring base address, 1 = ring length in elements, 2 = start index (also loads the read index), 3 = write index.
- R11: A ring filled to capacity, where the write index is one behind the read index in ring order, yields exactly length−1 fetches before its pending bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_sel | input | 2 | Field select (see R10) |
| cfg_wdata | input | ADDR_W | Write data |
| db_valid | input | 1 | Doorbell strike |
| db_ch | input | CH_W | Doorbell channel |
| crst_valid | input | 1 | Per-channel reset strobe |
| crst_ch | input | CH_W | Channel to reset |
| fetch_valid | output | 1 | Element fetch request valid |
| fetch_ready | input | 1 | Consumer accepts the request |
| fetch_ch | output | CH_W | Channel of the request |
| fetch_addr | output | ADDR_W | Byte address of the element |
| elem_ack | input | 1 | Fetched element returned |
| elem_chain | input | 1 | Chain bit of the returned element |
| done_valid | output | 1 | Descriptor completed (one-cycle pulse) |
| done_ch | output | CH_W | Channel of the completed descriptor |
| pend_mask | output | NUM_CH | Channels holding a doorbell with work |
| db_ign_cnt | output | CNT_W | Count of doorbells dropped on empty rings |

## Verification
The assertions assume the following about the inputs:
- `elem_ack` arrives only while a taken fetch is awaiting its element.
- A channel's start or read index is never rewritten, and the channel never reset, while it is the target of a request or an outstanding fetch.
- The host never moves a write index past the full point.

The bench keeps to these rules. It raises `elem_ack` only after it has seen the handshake and `fetch_valid` fall. It resets only a channel that is waiting and not granted. It computes every write index as the read index plus a count of at most length−1.

// File: rtl/tr_pkg.sv
package tr_pkg;
  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_LEN   = 2'd1,
    SEL_START = 2'd2,
    SEL_WP    = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } fsm_e;
endpackage

// File: rtl/tr_chan_store.sv
module tr_chan_store #(
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 32,
  parameter int CH_W   = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [CH_W-1:0]                cfg_ch,
  input  logic [1:0]                     cfg_sel,
  input  logic [ADDR_W-1:0]              cfg_wdata,
  input  logic                           db_valid,
  input  logic [CH_W-1:0]                db_ch,
  input  logic                           crst_valid,
  input  logic [CH_W-1:0]                crst_ch,
  input  logic                           adv_valid,
  input  logic [CH_W-1:0]                adv_ch,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  base_o,
  output logic [NUM_CH-1:0][PTR_W-1:0]   rp_o,
  output logic [NUM_CH-1:0]              pend_o,
  output logic [NUM_CH-1:0]              empty_o,
  output logic                           db_ignored
);
  import tr_pkg::*;

  logic [NUM_CH-1:0] ign;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [ADDR_W-1:0] base_q;
    logic [PTR_W:0]    len_q;
    logic [PTR_W-1:0]  start_q, rp_q, wp_q, rp_inc, rp_nx, wp_nx;
    logic              pend_q, pend_nx, empty_nx;
    logic              w_hit, db_hit, rst_hit, adv_hit;

    assign w_hit   = cfg_we && (cfg_ch == CH_W'(g));
    assign db_hit  = db_valid && (db_ch == CH_W'(g));
    assign rst_hit = crst_valid && (crst_ch == CH_W'(g));
    assign adv_hit = adv_valid && (adv_ch == CH_W'(g));

    // wrap to zero after the last element of the ring
    assign rp_inc = (({1'b0, rp_q} + 1'b1) == len_q) ? '0 : rp_q + 1'b1;

    always_comb begin
      rp_nx = rp_q;
      if (rst_hit)
        rp_nx = start_q;
      else if (w_hit && cfg_sel == SEL_START)
        rp_nx = cfg_wdata[PTR_W-1:0];
      else if (adv_hit)
        rp_nx = rp_inc;
    end

    assign wp_nx    = (w_hit && cfg_sel == SEL_WP) ? cfg_wdata[PTR_W-1:0] : wp_q;
    assign empty_nx = (rp_nx == wp_nx);

    always_comb begin
      pend_nx = pend_q;
      if (rst_hit || empty_nx)
        pend_nx = 1'b0;
      else if (db_hit)
        pend_nx = 1'b1;
    end

    assign ign[g] = db_hit && empty_nx;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q  <= '0;
        len_q   <= '0;
        start_q <= '0;
        rp_q    <= '0;
        wp_q    <= '0;
        pend_q  <= 1'b0;
      end else begin
        if (w_hit && cfg_sel == SEL_BASE)  base_q  <= cfg_wdata;
        if (w_hit && cfg_sel == SEL_LEN)   len_q   <= cfg_wdata[PTR_W:0];
        if (w_hit && cfg_sel == SEL_START) start_q <= cfg_wdata[PTR_W-1:0];
        rp_q   <= rp_nx;
        wp_q   <= wp_nx;
        pend_q <= pend_nx;
      end
    end

    assign base_o[g]  = base_q;
    assign rp_o[g]    = rp_q;
    assign pend_o[g]  = pend_q;
    assign empty_o[g] = (rp_q == wp_q);
  end

  assign db_ignored = |ign;
endmodule

// File: rtl/tr_rr_arb.sv
module tr_rr_arb #(
  parameter int N    = 8,
  parameter int CH_W = 3
) (
  input  logic [N-1:0]    req_i,
  input  logic [CH_W-1:0] last_i,
  output logic            gnt_any,
  output logic [CH_W-1:0] gnt_ch
);
  int idx;

  // walk downward so the nearest channel after last_i is written last
  always_comb begin
    gnt_any = 1'b0;
    gnt_ch  = '0;
    idx     = 0;
    for (int k = N; k >= 1; k--) begin
      idx = (int'(last_i) + k) % N;
      if (req_i[idx]) begin
        gnt_any = 1'b1;
        gnt_ch  = CH_W'(idx);
      end
    end
  end
endmodule

// File: rtl/tr_ring_tracker.sv
module tr_ring_tracker #(
  parameter int NUM_CH     = 8,
  parameter int PTR_W      = 8,
  parameter int ADDR_W     = 32,
  parameter int ELEM_BYTES = 16,
  parameter int CNT_W      = 16,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              db_valid,
  input  logic [CH_W-1:0]   db_ch,
  input  logic              crst_valid,
  input  logic [CH_W-1:0]   crst_ch,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [CH_W-1:0]   fetch_ch,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              elem_ack,
  input  logic              elem_chain,
  output logic              done_valid,
  output logic [CH_W-1:0]   done_ch,
  output logic [NUM_CH-1:0] pend_mask,
  output logic [CNT_W-1:0]  db_ign_cnt
);
  import tr_pkg::*;

  localparam int ELEM_SH = $clog2(ELEM_BYTES);

  fsm_e                          state_q;
  logic [CH_W-1:0]               cur_q, last_q, gnt_ch;
  logic                          lock_q, gnt_any, db_ign, adv_valid;
  logic [NUM_CH-1:0]             pend_w, empty_w, req_w;
  logic [NUM_CH-1:0][ADDR_W-1:0] base_w;
  logic [NUM_CH-1:0][PTR_W-1:0]  rp_w;

  assign adv_valid = (state_q == ST_WAIT) && elem_ack;

  tr_chan_store #(
    .NUM_CH(NUM_CH), .PTR_W(PTR_W), .ADDR_W(ADDR_W), .CH_W(CH_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .db_valid(db_valid), .db_ch(db_ch),
    .crst_valid(crst_valid), .crst_ch(crst_ch),
    .adv_valid(adv_valid), .adv_ch(cur_q),
    .base_o(base_w), .rp_o(rp_w), .pend_o(pend_w), .empty_o(empty_w),
    .db_ignored(db_ign)
  );

  assign req_w = pend_w & ~empty_w;

  tr_rr_arb #(.N(NUM_CH), .CH_W(CH_W)) arb_i (
    .req_i(req_w), .last_i(last_q), .gnt_any(gnt_any), .gnt_ch(gnt_ch)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_q      <= '0;
      last_q     <= CH_W'(NUM_CH - 1);
      lock_q     <= 1'b0;
      done_valid <= 1'b0;
      done_ch    <= '0;
      db_ign_cnt <= '0;
    end else begin
      done_valid <= 1'b0;
      if (db_ign) db_ign_cnt <= db_ign_cnt + 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (lock_q) begin
            if (req_w[cur_q]) state_q <= ST_REQ;
          end else if (gnt_any) begin
            cur_q   <= gnt_ch;
            last_q  <= gnt_ch;
            state_q <= ST_REQ;
          end
        end
        ST_REQ:  if (fetch_ready) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (elem_ack) begin
            state_q <= ST_IDLE;
            lock_q  <= elem_chain;
            if (!elem_chain) begin
              done_valid <= 1'b1;
              done_ch    <= cur_q;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (crst_valid && crst_ch == cur_q && state_q == ST_IDLE) lock_q <= 1'b0;
    end
  end

  assign fetch_valid = (state_q == ST_REQ);
  assign fetch_ch    = cur_q;
  assign fetch_addr  = base_w[cur_q] + (ADDR_W'(rp_w[cur_q]) << ELEM_SH);
  assign pend_mask   = pend_w;
endmodule

// File: rtl/tr_ring_tracker_chk.sv
module tr_ring_tracker_chk #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 32,
  parameter int CH_W   = 3,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [CH_W-1:0]   fetch_ch,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              elem_ack,
  input logic              elem_chain,
  input logic              done_valid,
  input logic [NUM_CH-1:0] pend_mask,
  input logic [NUM_CH-1:0] empty_mask,
  input logic [CNT_W-1:0]  db_ign_cnt
);
  // R4: a stalled request keeps its payload
  a_r4_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_addr) && $stable(fetch_ch));

  // R9: one outstanding fetch
  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready |=> !fetch_valid);

  // R7: completion only follows an unchained acknowledge
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(elem_ack && !elem_chain));

  // R2: pending implies a non-empty ring
  a_r2_pend_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_mask & empty_mask) == '0);

  // R3: ignored-doorbell counter moves by at most one per cycle
  a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (db_ign_cnt == $past(db_ign_cnt)) || (db_ign_cnt == $past(db_ign_cnt) + 1'b1));
endmodule

bind tr_ring_tracker tr_ring_tracker_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
  .fetch_ch(fetch_ch), .fetch_addr(fetch_addr),
  .elem_ack(elem_ack), .elem_chain(elem_chain),
  .done_valid(done_valid), .pend_mask(pend_mask),
  .empty_mask(empty_w), .db_ign_cnt(db_ign_cnt)
);

// File: tb/tr_ring_tracker_tb_top.sv
module tr_ring_tracker_tb_top;
  localparam int N   = 4;
  localparam int PW  = 3;
  localparam int AW  = 32;
  localparam int EB  = 16;
  localparam int CW  = 8;
  localparam int CHW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, db_valid, crst_valid, fetch_ready, elem_ack, elem_chain;
  logic [CHW-1:0] cfg_ch, db_ch, crst_ch, fetch_ch, done_ch;
  logic [1:0] cfg_sel;
  logic [AW-1:0] cfg_wdata, fetch_addr;
  logic fetch_valid, done_valid;
  logic [N-1:0] pend_mask;
  logic [CW-1:0] db_ign_cnt;

  always #2 clk = ~clk;

  tr_ring_tracker #(.NUM_CH(N), .PTR_W(PW), .ADDR_W(AW), .ELEM_BYTES(EB), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .db_valid(db_valid), .db_ch(db_ch), .crst_valid(crst_valid), .crst_ch(crst_ch),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_ch(fetch_ch),
    .fetch_addr(fetch_addr), .elem_ack(elem_ack), .elem_chain(elem_chain),
    .done_valid(done_valid), .done_ch(done_ch), .pend_mask(pend_mask),
    .db_ign_cnt(db_ign_cnt)
  );

  int n_checks = 0, n_fail = 0, n_serve = 0;
  int m_base[N], m_len[N], m_start[N], m_rp[N], m_wp[N];
  bit m_pend[N];
  int m_last = N - 1, m_lock = -1, m_ign = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rem(input int c);
    return (m_wp[c] - m_rp[c] + m_len[c]) % m_len[c];
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  // R10 field codes: 0 base, 1 length, 2 start (+read index), 3 write index
  task automatic cfg(input int c, input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CHW'(c); cfg_sel = 2'(sel); cfg_wdata = AW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      0: m_base[c] = val;
      1: m_len[c] = val;
      2: begin m_start[c] = val; m_rp[c] = val; end
      default: m_wp[c] = val;
    endcase
    if (sel >= 2 && m_len[c] > 0 && rem(c) == 0) m_pend[c] = 0;
  endtask

  task automatic ring(input int c);
    @(negedge clk);
    db_valid = 1'b1; db_ch = CHW'(c);
    @(negedge clk);
    db_valid = 1'b0;
    if (rem(c) == 0) m_ign++;
    else m_pend[c] = 1;
    chk(pend_mask[c] == m_pend[c], "R2/R3 pending bit after doorbell", pend_mask[c], m_pend[c]);
    chk(db_ign_cnt == CW'(m_ign), "R3 ignored doorbell count", db_ign_cnt, m_ign);
  endtask

  // mode 0: never chain; mode 1: chain until the channel's last element
  task automatic serve(input int mode);
    int exp_ch, stall, waited;
    bit chain;
    exp_ch = -1;
    if (m_lock >= 0) exp_ch = m_lock;
    else
      for (int k = N; k >= 1; k--)
        if (m_pend[(m_last + k) % N]) exp_ch = (m_last + k) % N;
    waited = 0;
    while (!fetch_valid && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    chk(fetch_valid == 1'b1, "R4 fetch request raised", fetch_valid, 1);
    chk(exp_ch >= 0 && fetch_ch == CHW'(exp_ch), "R6 granted channel", fetch_ch, exp_ch);
    if (exp_ch < 0) return;
    chk(fetch_addr == AW'(m_base[exp_ch] + m_rp[exp_ch] * EB), "R4 fetch address",
        fetch_addr, m_base[exp_ch] + m_rp[exp_ch] * EB);
    stall = n_serve % 3;
    n_serve++;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(fetch_valid && fetch_ch == CHW'(exp_ch) &&
          fetch_addr == AW'(m_base[exp_ch] + m_rp[exp_ch] * EB),
          "R4 request held under back-pressure", fetch_addr, m_base[exp_ch] + m_rp[exp_ch] * EB);
    end
    fetch_ready = 1'b1;
    @(negedge clk);
    fetch_ready = 1'b0;
    chk(fetch_valid == 1'b0, "R9 no second request before ack", fetch_valid, 0);
    chain = (mode == 1) && (rem(exp_ch) > 1);
    elem_ack = 1'b1; elem_chain = chain;
    @(negedge clk);
    elem_ack = 1'b0; elem_chain = 1'b0;
    m_rp[exp_ch] = (m_rp[exp_ch] + 1) % m_len[exp_ch];
    if (rem(exp_ch) == 0) m_pend[exp_ch] = 0;
    m_last = exp_ch;
    m_lock = chain ? exp_ch : -1;
    chk(done_valid == !chain, "R7 completion pulse", done_valid, !chain);
    if (!chain) chk(done_ch == CHW'(exp_ch), "R7 completion channel", done_ch, exp_ch);
    chk(pend_mask[exp_ch] == m_pend[exp_ch], "R5 pending after advance", pend_mask[exp_ch], m_pend[exp_ch]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int w;
    rst_n = 1'b0; cfg_we = 0; cfg_ch = 0; cfg_sel = 0; cfg_wdata = 0;
    db_valid = 0; db_ch = 0; crst_valid = 0; crst_ch = 0;
    fetch_ready = 0; elem_ack = 0; elem_chain = 0;
    for (int c = 0; c < N; c++) begin
      m_base[c] = 0; m_len[c] = 0; m_start[c] = 0; m_rp[c] = 0; m_wp[c] = 0; m_pend[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pend_mask == '0, "R1 pend_mask", pend_mask, 0);
    chk(fetch_valid == 1'b0, "R1 fetch_valid", fetch_valid, 0);
    chk(done_valid == 1'b0, "R1 done_valid", done_valid, 0);
    chk(db_ign_cnt == '0, "R1 counter", db_ign_cnt, 0);

    // R10 programming of every channel
    for (int c = 0; c < N; c++) begin
      cfg(c, 0, (c + 1) * 'h1000 + c * 'h40);
      cfg(c, 1, 4 + c);
      cfg(c, 2, c);
      cfg(c, 3, c);
    end

    // R3 doorbells on empty rings
    for (int c = 0; c < N; c++) ring(c);
    @(negedge clk);
    chk(fetch_valid == 1'b0, "R3 no fetch from ignored doorbells", fetch_valid, 0);

    // R2 write index alone does not raise pending
    cfg(1, 3, (m_rp[1] + 2) % m_len[1]);
    repeat (2) @(negedge clk);
    chk(pend_mask == '0, "R2 write index without doorbell", pend_mask, 0);
    chk(fetch_valid == 1'b0, "R2 no fetch without doorbell", fetch_valid, 0);
    ring(1);
    serve(0);
    serve(0);

    // R5 R11 R7 sweep of every count up to ring capacity, chained on even counts
    for (int c = 0; c < N; c++) begin
      for (int n = 1; n < m_len[c]; n++) begin
        cfg(c, 3, (m_rp[c] + n) % m_len[c]);
        ring(c);
        for (int k = 0; k < n; k++) serve((n % 2 == 0) ? 1 : 0);
        @(negedge clk);
        chk(pend_mask == '0, "R11 ring drained after count", pend_mask, 0);
        chk(fetch_valid == 1'b0, "R11 no extra fetch", fetch_valid, 0);
      end
    end

    // R6 R7 round robin with a chained descriptor on channel 0
    for (int k = 0; k < N; k++) begin
      int c;
      c = (m_last + 1 + k) % N;
      cfg(c, 3, (m_rp[c] + ((c == 0) ? 3 : 2)) % m_len[c]);
    end
    for (int k = 0; k < N; k++) ring((m_last + 1 + k) % N);
    for (int k = 0; k < 9; k++) begin
      if (m_lock < 0 && !m_pend[0] || m_lock >= 0 && m_lock != 0) serve(0);
      else serve(1);
    end
    @(negedge clk);
    chk(pend_mask == '0, "R6 all channels served", pend_mask, 0);

    // R6 second round, unchained interleave
    for (int k = 0; k < N; k++) cfg((m_last + 1 + k) % N, 3,
                                    (m_rp[(m_last + 1 + k) % N] + 2) % m_len[(m_last + 1 + k) % N]);
    for (int k = 0; k < N; k++) ring((m_last + 1 + k) % N);
    for (int k = 0; k < 2 * N; k++) serve(0);

    // R8 channel reset on a waiting channel while channel 3 holds the grant
    cfg(3, 3, (m_rp[3] + 1) % m_len[3]);
    ring(3);
    w = (m_start[2] + 4) % m_len[2];
    if (w == m_rp[2]) w = (m_start[2] + 3) % m_len[2];
    cfg(2, 3, w);
    ring(2);
    @(negedge clk);
    crst_valid = 1'b1; crst_ch = 2'd2;
    @(negedge clk);
    crst_valid = 1'b0;
    m_rp[2] = m_start[2];
    m_pend[2] = 0;
    chk(pend_mask[2] == 1'b0, "R8 pending dropped by channel reset", pend_mask[2], 0);
    serve(0);
    @(negedge clk);
    chk(fetch_valid == 1'b0, "R8 reset channel not served", fetch_valid, 0);
    ring(2);
    while (m_pend[2]) serve(0);
    @(negedge clk);
    chk(pend_mask == '0, "R8 final drain", pend_mask, 0);
    summary();
  end
endmodule